// File: doc/BRIEF.md
# Debounced Input Port with Status and Interrupt

This block is a memory-mapped input peripheral for a small bank of switches or push keys. It filters the raw pins and keeps a clean, debounced copy of them. Software reads that copy through a data register. A control/status register reports whether a fresh value is waiting and whether one was lost. It also holds an interrupt-enable bit that gates the interrupt request line.

The bus is a plain single-master processor bus: an address, a write strobe, a read strobe, write data and read data. Read data is combinational. It is zero whenever neither register is addressed by a read, so many such devices can be OR-combined onto one return path. The base addresses and the input width are parameters. The defaults give a ten-bit switch port with data at 0xF0000014 and control at 0xF0000114. A four-bit key port uses 0xF0000010 and 0xF0000110.

The raw pins pass through a two-flop synchronizer. The value then has to hold steady for a debounce window of STABLE_MS milliseconds, derived from CLK_HZ, before it is accepted.

Top module: `dbin_dev`

## Requirements
- R1: After reset the control/status register reads 0, the data register reads 0 and `irq` is low.
- R2: The data register takes a new raw value only after the synchronized input has held that value for STABLE_MS milliseconds (CLK_HZ/1000*STABLE_MS clock cycles).
- R3: A raw change that lasts for fewer cycles than the debounce window leaves the data register and the Ready bit unchanged.
- R4: Ready (control bit 0) becomes 1 whenever the data register changes. A bus read of the data register clears it. Bus writes to bit 0 have no effect.
- R5: Overrun (control bit 2) becomes 1 when the data register changes while Ready is 1. A control write with bit 2 equal to 0 clears it, and a control write with bit 2 equal to 1 leaves it unchanged.
- R6: Interrupt Enable (control bit 8) is readable and takes bit 8 of every control write. `irq` is high exactly when Ready and Interrupt Enable are both 1.
- R7: Bus writes to the data register are ignored.
- R8: `bus_rdata` is 0 when the read strobe is low, when a write is in progress, or when the address matches neither register. Control bits other than 0, 2 and 8 read as 0, and the data value is zero-extended.
- R9: When a read of the data register and a data change fall in the same cycle, Ready ends at 1. Overrun is decided from the Ready value held before that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_in | input | DATA_W | Raw, asynchronous switch or key levels |
| bus_addr | input | BUS_W | Bus address |
| bus_we | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data; zero when not selected |
| irq | output | 1 | Interrupt request (Ready and Interrupt Enable) |

## Verification
The assertions assume that the read and write strobes are never high together, and that reset is held for at least one edge before any traffic. They also rely on the raw input changing no faster than the synchronizer can follow. The bench raises only one strobe at a time and changes `raw_in` only between edges. It holds every deliberate value for well over the debounce window and every glitch for half of it. The bench shrinks CLK_HZ so that the window is ten cycles long, which keeps the run short while leaving the counter path unchanged.

// File: rtl/dbin_pkg.sv
package dbin_pkg;
  // Control/status bit positions; software decodes these.
  localparam int RDY_BIT = 0;
  localparam int OVR_BIT = 2;
  localparam int IE_BIT  = 8;

  typedef struct packed {
    logic ie;
    logic ovr;
    logic rdy;
  } dbin_stat_t;
endpackage

// File: rtl/dbin_sync.sv
module dbin_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] q_out
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st_q[0] <= '0;
    else     st_q[0] <= d_in;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st_q[i] <= '0;
      else     st_q[i] <= st_q[i-1];
    end
  end

  assign q_out = st_q[STAGES-1];
endmodule

// File: rtl/dbin_debounce.sv
module dbin_debounce #(
  parameter int          W         = 10,
  parameter int unsigned CLK_HZ    = 125_000_000,
  parameter int unsigned STABLE_MS = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] sync_in,
  output logic [W-1:0] stable_q,
  output logic         chg_p
);
  localparam int unsigned LIMIT = (CLK_HZ / 1000) * STABLE_MS;
  localparam int          CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [W-1:0]     cand_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cand_q   <= '0;
      cnt_q    <= '0;
      stable_q <= '0;
      chg_p    <= 1'b0;
    end else begin
      chg_p <= 1'b0;
      if (sync_in != cand_q) begin
        cand_q <= sync_in;
        cnt_q  <= '0;
      end else if (cand_q != stable_q) begin
        if (cnt_q == LAST) begin
          stable_q <= cand_q;
          chg_p    <= 1'b1;
          cnt_q    <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  // R2
  stab_win_chk: assert property (@(posedge clk) disable iff (rst)
    (stable_q != $past(stable_q)) |->
      ((stable_q == $past(cand_q)) && ($past(cnt_q) == LAST)));

  // R3
  cand_restart_chk: assert property (@(posedge clk) disable iff (rst)
    (cand_q != $past(cand_q)) |-> (cnt_q == '0));
endmodule

// File: rtl/dbin_status.sv
module dbin_status
  import dbin_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       chg_p,
  input  logic       rd_data,
  input  logic       wr_ctrl,
  input  logic       wr_ovr,
  input  logic       wr_ie,
  output dbin_stat_t stat
);
  always_ff @(posedge clk) begin
    if (rst) begin
      stat <= '0;
    end else begin
      if (chg_p)        stat.rdy <= 1'b1;
      else if (rd_data) stat.rdy <= 1'b0;

      if (chg_p && stat.rdy)     stat.ovr <= 1'b1;
      else if (wr_ctrl && !wr_ovr) stat.ovr <= 1'b0;

      if (wr_ctrl) stat.ie <= wr_ie;
    end
  end

  // R4
  rdy_set_chk: assert property (@(posedge clk) disable iff (rst)
    chg_p |=> stat.rdy);

  // R4
  rdy_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_data && !chg_p) |=> !stat.rdy);

  // R5
  ovr_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (stat.ovr && !(wr_ctrl && !wr_ovr)) |=> stat.ovr);

  // R5
  ovr_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat.ovr) |-> $past(chg_p && stat.rdy));
endmodule

// File: rtl/dbin_dev.sv
module dbin_dev
  import dbin_pkg::*;
#(
  parameter int              DATA_W    = 10,
  parameter int              BUS_W     = 32,
  parameter logic [BUS_W-1:0] DATA_ADDR = 32'hF000_0014,
  parameter logic [BUS_W-1:0] CTRL_ADDR = 32'hF000_0114,
  parameter int unsigned     CLK_HZ    = 125_000_000,
  parameter int unsigned     STABLE_MS = 10,
  parameter int              SYNC_N    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] raw_in,
  input  logic [BUS_W-1:0]  bus_addr,
  input  logic              bus_we,
  input  logic              bus_rd,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              irq
);
  logic [DATA_W-1:0] sync_v;
  logic [DATA_W-1:0] stab_v;
  logic              chg_p;
  dbin_stat_t        stat;

  logic hit_data, hit_ctrl, rd_data, rd_ctrl, wr_ctrl;

  assign hit_data = (bus_addr == DATA_ADDR);
  assign hit_ctrl = (bus_addr == CTRL_ADDR);
  assign rd_data  = hit_data && bus_rd && !bus_we;
  assign rd_ctrl  = hit_ctrl && bus_rd && !bus_we;
  assign wr_ctrl  = hit_ctrl && bus_we;

  dbin_sync #(.W(DATA_W), .STAGES(SYNC_N)) sync_i (
    .clk(clk), .rst(rst), .d_in(raw_in), .q_out(sync_v)
  );

  dbin_debounce #(.W(DATA_W), .CLK_HZ(CLK_HZ), .STABLE_MS(STABLE_MS)) deb_i (
    .clk(clk), .rst(rst), .sync_in(sync_v), .stable_q(stab_v), .chg_p(chg_p)
  );

  dbin_status stat_i (
    .clk(clk), .rst(rst), .chg_p(chg_p), .rd_data(rd_data),
    .wr_ctrl(wr_ctrl), .wr_ovr(bus_wdata[OVR_BIT]), .wr_ie(bus_wdata[IE_BIT]),
    .stat(stat)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_data) begin
      bus_rdata[DATA_W-1:0] = stab_v;
    end else if (rd_ctrl) begin
      bus_rdata[RDY_BIT] = stat.rdy;
      bus_rdata[OVR_BIT] = stat.ovr;
      bus_rdata[IE_BIT]  = stat.ie;
    end
  end

  assign irq = stat.rdy & stat.ie;

  // R8
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd || bus_we) |-> (bus_rdata == '0));

  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!irq && stab_v == '0));
endmodule

// File: tb/dbin_dev_tb_top.sv
module dbin_dev_tb_top;
  localparam int DW = 10;
  localparam int BW = 32;
  localparam logic [BW-1:0] DA = 32'hF000_0014;
  localparam logic [BW-1:0] CA = 32'hF000_0114;
  localparam int WIN = 10;          // CLK_HZ=1000, STABLE_MS=10
  localparam int SETTLE = WIN + 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] raw_in = '0;
  logic [BW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic bus_rd = 1'b0;
  logic [BW-1:0] bus_wdata = '0;
  logic [BW-1:0] bus_rdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [BW-1:0] exp_q [$];
  string         tag_q [$];

  always #4 clk = ~clk;   // 125 MHz

  dbin_dev #(.DATA_W(DW), .BUS_W(BW), .DATA_ADDR(DA), .CTRL_ADDR(CA),
             .CLK_HZ(1000), .STABLE_MS(10), .SYNC_N(2)) dut_i (
    .clk(clk), .rst(rst), .raw_in(raw_in), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // Monitor: pops one expectation per read strobe, mid-cycle.
  always @(negedge clk) begin
    if (bus_rd && exp_q.size() > 0) begin
      logic [BW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input string t, input logic [BW-1:0] act, input logic [BW-1:0] ex);
    checks++;
    if (act !== ex) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, ex);
    end
  endtask

  task automatic bus_read(input logic [BW-1:0] a, input logic [BW-1:0] ex, input string t);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(ex); tag_q.push_back(t);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [BW-1:0] a, input logic [BW-1:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic set_raw(input logic [DW-1:0] v);
    @(posedge clk); #1;
    raw_in = v;
    wait_cyc(SETTLE);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    wait_cyc(4);
    rst = 1'b0;
    // R1 reset state
    @(negedge clk); chk("R1 irq", {31'd0, irq}, 0);
    bus_read(CA, 0, "R1 ctrl");
    bus_read(DA, 0, "R1 data");

    // R2 / R4: accept a new value, ready set then cleared by data read
    set_raw(10'h155);
    bus_read(CA, 32'h001, "R4 ready set");
    bus_read(DA, 32'h155, "R2 data");
    bus_read(CA, 32'h000, "R4 ready cleared by read");

    // R3: short glitch
    @(posedge clk); #1; raw_in = 10'h0AA;
    wait_cyc(WIN / 2);
    raw_in = 10'h155;
    wait_cyc(SETTLE);
    bus_read(CA, 32'h000, "R3 ready unchanged");
    bus_read(DA, 32'h155, "R3 data unchanged");

    // R4: write to ready bit ignored
    set_raw(10'h2AA);
    bus_write(CA, 32'h000);
    bus_read(CA, 32'h001, "R4 write ignored");

    // R5: overrun set, write-one ignored, write-zero clears
    set_raw(10'h3FF);
    bus_read(CA, 32'h005, "R5 overrun set");
    bus_write(CA, 32'h004);
    bus_read(CA, 32'h005, "R5 write one ignored");
    bus_write(CA, 32'h000);
    bus_read(CA, 32'h001, "R5 write zero clears");

    // R7: data register write ignored
    bus_write(DA, 32'h0000_0000);
    bus_read(DA, 32'h3FF, "R7 data write ignored");
    bus_read(CA, 32'h000, "R7 ctrl after read");

    // R6: interrupt enable and irq
    bus_write(CA, 32'h100);
    bus_read(CA, 32'h100, "R6 ie readback");
    @(negedge clk); chk("R6 irq low, no ready", {31'd0, irq}, 0);
    set_raw(10'h001);
    @(negedge clk); chk("R6 irq high", {31'd0, irq}, 1);
    bus_read(CA, 32'h101, "R6 ctrl");
    bus_read(DA, 32'h001, "R6 data");
    @(negedge clk); chk("R6 irq drops after read", {31'd0, irq}, 0);

    // R8: unselected / no strobe / unused bits
    @(posedge clk); #1; bus_addr = DA; bus_rd = 1'b0;
    @(negedge clk); chk("R8 no strobe", bus_rdata, 0);
    bus_read(32'hF000_0018, 0, "R8 other address");
    bus_write(CA, 32'hFFFF_FFFF);
    bus_read(CA, 32'h100, "R8 unused bits zero");

    // R9: data read held through a change; change must win for one cycle
    begin
      int hi;
      hi = 0;
      @(posedge clk); #1;
      bus_addr = DA; bus_rd = 1'b1; raw_in = 10'h000;
      for (int i = 0; i < SETTLE; i++) begin
        @(negedge clk);
        if (irq) hi++;
      end
      @(posedge clk); #1; bus_rd = 1'b0;
      chk("R9 ready pulse count", hi, 1);
    end
    bus_read(CA, 32'h100, "R9 ctrl after");
    bus_read(DA, 32'h000, "R9 data");

    wait_cyc(2);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule